// File: doc/BRIEF.md
# Power-State Sequencer with Fault Restart

This block sequences a power-management device through its power states: off, start-up, active and hibernate. A fifth state holds the rails down between automatic restart attempts. It brings the device up from off when the ON pin is pressed or software sets the chip-on bit. It releases the system reset once the rails report start-up done with no enabled fault present. It takes the device down when software clears the chip-on bit, when the ON pin is held long enough, or when an enabled fault cannot be recovered.

Undervoltage and overcurrent flags each have their own enable. A flag whose enable is 0 has no effect. When an enabled fault is seen, the power-cycle bit chooses the response. With the bit at 0 the device shuts down at once. With the bit at 1 it retries start-up after a fixed wait, a bounded number of times. When the retry budget runs out, it gives up, shuts down and clears the attempt count. Every shutdown clears the chip-on bit and emits a one-cycle register-reset pulse. A separate option emits the same pulse when the device wakes from hibernate.

All timers count a 1 ms `tick_i` strobe. There are three timers: the start-up window (`STARTUP_MS`), the wait between restarts (`RETRY_MS`) and the ON-pin hold-to-off time (`OFF_LONG_MS` or `OFF_SHORT_MS`).

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After asynchronous reset the state is OFF and the attempt count is 0. The chip-on and power-cycle bits are 0 and the hibernate-reset bit is 1. The rails are off, both resets are asserted low, and no register-reset pulse is issued. `state_o` encodes OFF=0, STARTUP=1, ACTIVE=2, HIBERNATE=3, RETRY_WAIT=4.
- R2: In OFF, either of two events moves the state to STARTUP on the next clock and sets the chip-on bit. One is the ON pin becoming asserted, where asserted means pin high when `on_pol_i`=0 and pin low when `on_pol_i`=1. The other is a control write with chip-on data 1. In STARTUP the rails are on, the memory reset is released and the system reset stays asserted.
- R3: In STARTUP, `start_done_i` high with no enabled fault moves the state to ACTIVE on the next clock. This clears the attempt count and releases the system reset.
- R4: A fault flag whose enable is 0 has no effect in any state. An enabled fault blocks the success of R3. STARTUP lasts at most `STARTUP_MS` ticks; when that window closes without success, the attempt has failed and the fault response applies.
- R5: Fault response with the power-cycle bit 0: the state goes to OFF with the shutdown actions of R8.
- R6: Fault response with the power-cycle bit 1 and the attempt count below `RETRY_MAX`: the attempt count increments and the state goes to RETRY_WAIT. With the rails off, RETRY_WAIT lasts `RETRY_MS` ticks and then enters STARTUP.
- R7: Fault response with the power-cycle bit 1 and the attempt count already at `RETRY_MAX`: the state goes to OFF and the count clears. A later start event again gets the full budget.
- R8: Every shutdown does the following: it enters OFF, pulses `reg_rst_o` for one cycle, clears the chip-on bit and the attempt count, turns the rails off, and asserts both resets.
- R9: A control write with chip-on data 0 in any state other than OFF causes a shutdown.
- R10: In ACTIVE, holding the ON pin asserted causes a shutdown. The hold time is `OFF_LONG_MS` ticks (10000) when `off_short_i`=0 and `OFF_SHORT_MS` ticks (5000) when it is 1. Releasing the pin earlier restarts the hold count.
- R11: `hib_req_i` in ACTIVE enters HIBERNATE, where the rails are off and both resets are released. `wake_i` with no enabled fault returns to ACTIVE, and `reg_rst_o` pulses for one cycle if and only if the hibernate-reset bit is 1.
- R12: `wake_i` in HIBERNATE with an enabled fault applies the fault response instead of returning to ACTIVE.
- R13: An enabled fault while in ACTIVE applies the fault response on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms timebase strobe, one clock wide |
| on_pin_i | input | 1 | ON pin level, already synchronised |
| on_pol_i | input | 1 | ON pin polarity: 0 active high, 1 active low |
| off_short_i | input | 1 | Hold-to-off time select: 0 long, 1 short |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_chip_on_i | input | 1 | Chip-on data for a control write |
| ctl_pcyc_i | input | 1 | Power-cycle data for a control write |
| ctl_hib_rst_i | input | 1 | Hibernate-reset option data for a control write |
| hib_req_i | input | 1 | Request to enter hibernate |
| wake_i | input | 1 | Request to leave hibernate |
| uv_flt_i | input | 1 | Undervoltage fault flag |
| uv_en_i | input | 1 | Undervoltage fault shuts down when 1 |
| oc_flt_i | input | 1 | Overcurrent fault flag |
| oc_en_i | input | 1 | Overcurrent fault shuts down when 1 |
| start_done_i | input | 1 | Rails report start-up complete |
| rails_en_o | output | 1 | Rail enable |
| sys_rst_n_o | output | 1 | System reset, active low |
| mem_rst_n_o | output | 1 | Memory reset, active low |
| reg_rst_o | output | 1 | One-cycle register-reset pulse |
| chip_on_o | output | 1 | Chip-on bit |
| state_o | output | 3 | Power state, encoded as in R1 |
| attempt_o | output | $clog2(RETRY_MAX+1) (4) | Restart attempts made since the last success or give-up |

## Verification
Random start-ups combine random fault flags, random enables and a random power-cycle bit, each with start-up done raised at once. This separates a blocked success that ends in a retry wait from one that ends in OFF, and both from a clean entry to ACTIVE. Disabled faults confirm that the enables gate the flags. A directed run with no start-up done walks the whole retry budget and measures each start-up window and wait in exact cycles. It then shows that a fresh start gets the budget back. ON-pin holds just short of and just past each hold time separate the two off-time settings. A hibernate round trip with the option bit at 1 and at 0 shows when the wake-up reset pulse is emitted.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_START  = 3'd1,
    PS_ACTIVE = 3'd2,
    PS_HIBER  = 3'd3,
    PS_WAIT   = 3'd4
  } pwr_state_e;

  // An enabled flag is the only kind of fault that changes the sequence.
  function automatic logic fault_kills(input logic uv, input logic uv_en,
                                       input logic oc, input logic oc_en);
    return (uv & uv_en) | (oc & oc_en);
  endfunction

  // Hold-to-off time in ticks for the selected setting.
  function automatic int unsigned hold_limit(input logic short_sel,
                                             input int unsigned long_t,
                                             input int unsigned short_t);
    return short_sel ? short_t : long_t;
  endfunction

  // No further restart once cycling is off or the budget is spent.
  function automatic logic give_up(input logic pcyc, input logic at_max);
    return !pcyc || at_max;
  endfunction

endpackage

// File: rtl/pwr_tick_timer.sv
`timescale 1ns/1ps
module pwr_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  assign hit = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (tick && !hit)  cnt_q <= cnt_q + 1'b1;
  end

  // R6 / R4: each tick before the limit advances the count by one
  p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && !hit) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: a clear always returns the count to zero
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_on_detect.sv
`timescale 1ns/1ps
module pwr_on_detect import pwr_seq_pkg::*; #(
  parameter int unsigned LONG_T  = 10000,
  parameter int unsigned SHORT_T = 5000,
  parameter int unsigned HW      = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic pol,
  input  logic short_sel,
  input  logic hold_en,
  output logic press_evt,
  output logic hold_off
);

  logic          pressed;
  logic          pressed_q;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] hold_lim;

  assign pressed   = pin ^ pol;
  assign press_evt = pressed && !pressed_q;
  assign hold_lim  = HW'(hold_limit(short_sel, LONG_T, SHORT_T));
  assign hold_off  = hold_en && pressed && (hold_q >= hold_lim);

  // Previous level resets to "pressed" so reset release makes no event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pressed_q <= 1'b1;
    else        pressed_q <= pressed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hold_q <= '0;
    else if (!hold_en || !pressed)      hold_q <= '0;
    else if (tick && hold_q < hold_lim) hold_q <= hold_q + 1'b1;
  end

  // R10: a release restarts the hold, so no off request follows at once
  p_release_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && !pressed) |=> (hold_q == '0));

  // R2: a press event needs a level change from released to pressed
  p_press_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt |=> !press_evt);

endmodule

// File: rtl/pwr_retry_ctr.sv
`timescale 1ns/1ps
module pwr_retry_ctr #(
  parameter int unsigned MAX = 8,
  parameter int unsigned W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  logic [W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign at_max = (cnt_q == W'(MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (inc && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  // R7: the attempt count never passes the budget
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(MAX));

  // R7 / R3: a clear empties the count on the next cycle
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl import pwr_seq_pkg::*; #(
  parameter int unsigned STARTUP_MS   = 50,
  parameter int unsigned RETRY_MS     = 200,
  parameter int unsigned RETRY_MAX    = 8,
  parameter int unsigned OFF_LONG_MS  = 10000,
  parameter int unsigned OFF_SHORT_MS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic on_pin_i,
  input  logic on_pol_i,
  input  logic off_short_i,
  input  logic ctl_wr_i,
  input  logic ctl_chip_on_i,
  input  logic ctl_pcyc_i,
  input  logic ctl_hib_rst_i,
  input  logic hib_req_i,
  input  logic wake_i,
  input  logic uv_flt_i,
  input  logic uv_en_i,
  input  logic oc_flt_i,
  input  logic oc_en_i,
  input  logic start_done_i,
  output logic rails_en_o,
  output logic sys_rst_n_o,
  output logic mem_rst_n_o,
  output logic reg_rst_o,
  output logic chip_on_o,
  output logic [2:0] state_o,
  output logic [$clog2(RETRY_MAX+1)-1:0] attempt_o
);

  localparam int unsigned CW   = $clog2(RETRY_MAX + 1);
  localparam int unsigned TMAX = (STARTUP_MS > RETRY_MS) ? STARTUP_MS : RETRY_MS;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned HMAX = (OFF_LONG_MS > OFF_SHORT_MS) ? OFF_LONG_MS : OFF_SHORT_MS;
  localparam int unsigned HW   = $clog2(HMAX + 1);

  pwr_state_e state_q, state_d;
  logic chip_on_q, pcyc_q, hib_rst_q, reg_rst_q;

  // Named internal events, visible to the assertions.
  logic kill, sw_on, sw_off, press_evt, hold_off, tmr_hit, at_max;
  logic ev_start, ev_success, ev_fail, ev_retry, ev_shutdown, ev_hib_exit;
  logic [TW-1:0] tmr_lim;
  logic [CW-1:0] attempts;

  assign kill   = fault_kills(uv_flt_i, uv_en_i, oc_flt_i, oc_en_i);
  assign sw_on  = ctl_wr_i && ctl_chip_on_i;
  assign sw_off = ctl_wr_i && !ctl_chip_on_i;

  pwr_on_detect #(
    .LONG_T (OFF_LONG_MS),
    .SHORT_T(OFF_SHORT_MS),
    .HW     (HW)
  ) u_on (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .pin      (on_pin_i),
    .pol      (on_pol_i),
    .short_sel(off_short_i),
    .hold_en  (state_q == PS_ACTIVE),
    .press_evt(press_evt),
    .hold_off (hold_off)
  );

  // One timer serves the start-up window and the retry wait: the two never overlap.
  assign tmr_lim = (state_q == PS_WAIT) ? TW'(RETRY_MS) : TW'(STARTUP_MS);

  pwr_tick_timer #(.W(TW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_d != state_q),
    .tick (tick_i),
    .limit(tmr_lim),
    .hit  (tmr_hit)
  );

  pwr_retry_ctr #(.MAX(RETRY_MAX), .W(CW)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_shutdown || ev_success),
    .inc   (ev_retry),
    .cnt   (attempts),
    .at_max(at_max)
  );

  always_comb begin
    state_d     = state_q;
    ev_start    = 1'b0;
    ev_success  = 1'b0;
    ev_fail     = 1'b0;
    ev_hib_exit = 1'b0;
    ev_retry    = 1'b0;
    ev_shutdown = 1'b0;
    unique case (state_q)
      PS_OFF: begin
        if (press_evt || sw_on) begin
          ev_start = 1'b1;
          state_d  = PS_START;
        end
      end
      PS_START: begin
        if (sw_off)                          ev_shutdown = 1'b1;
        else if (start_done_i && !kill) begin
          ev_success = 1'b1;
          state_d    = PS_ACTIVE;
        end
        else if (tmr_hit)                    ev_fail = 1'b1;
      end
      PS_ACTIVE: begin
        if (sw_off || hold_off)  ev_shutdown = 1'b1;
        else if (kill)           ev_fail     = 1'b1;
        else if (hib_req_i)      state_d     = PS_HIBER;
      end
      PS_HIBER: begin
        if (sw_off) ev_shutdown = 1'b1;
        else if (wake_i) begin
          if (kill) ev_fail = 1'b1;
          else begin
            ev_hib_exit = 1'b1;
            state_d     = PS_ACTIVE;
          end
        end
      end
      PS_WAIT: begin
        if (sw_off)       ev_shutdown = 1'b1;
        else if (tmr_hit) state_d     = PS_START;
      end
      default: state_d = PS_OFF;
    endcase
    if (ev_fail) begin
      if (give_up(pcyc_q, at_max)) ev_shutdown = 1'b1;
      else                         ev_retry    = 1'b1;
    end
    if (ev_retry)    state_d = PS_WAIT;
    if (ev_shutdown) state_d = PS_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_OFF;
      chip_on_q <= 1'b0;
      pcyc_q    <= 1'b0;
      hib_rst_q <= 1'b1;
      reg_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      reg_rst_q <= ev_shutdown || (ev_hib_exit && hib_rst_q);
      if (ctl_wr_i) begin
        pcyc_q    <= ctl_pcyc_i;
        hib_rst_q <= ctl_hib_rst_i;
      end
      if (ev_shutdown)   chip_on_q <= 1'b0;
      else if (ctl_wr_i) chip_on_q <= ctl_chip_on_i;
      else if (ev_start) chip_on_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign attempt_o   = attempts;
  assign chip_on_o   = chip_on_q;
  assign reg_rst_o   = reg_rst_q;
  assign rails_en_o  = (state_q == PS_START) || (state_q == PS_ACTIVE);
  assign sys_rst_n_o = (state_q == PS_ACTIVE) || (state_q == PS_HIBER);
  assign mem_rst_n_o = (state_q != PS_OFF);

  // R2: an ON press in OFF starts the sequence
  p_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_OFF && press_evt) |=> (state_o == 3'd1));

  // R3: success lands in ACTIVE with an empty attempt count
  p_success_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_START && start_done_i && !kill && !sw_off)
    |=> (state_o == 3'd2 && attempt_o == '0));

  // R8: each entry to OFF carries the register pulse and clears chip-on and count
  p_off_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_OFF) |=> (state_q != PS_OFF || (reg_rst_o && !chip_on_o && attempt_o == '0)));

  // R6: each entry to the retry wait adds exactly one attempt
  p_wait_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_WAIT) |=> (state_q != PS_WAIT || attempt_o == $past(attempt_o) + 1'b1));

  // R11: with the option cleared, waking from hibernate gives no register pulse
  p_hib_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_HIBER && wake_i && !kill && !sw_off && !hib_rst_q) |=> !reg_rst_o);

endmodule

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;

  localparam int L  = 50;
  localparam int RW = 200;
  localparam int RM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic on_pin_i = 1'b0, on_pol_i = 1'b0, off_short_i = 1'b0;
  logic ctl_wr_i = 1'b0, ctl_chip_on_i = 1'b0, ctl_pcyc_i = 1'b0, ctl_hib_rst_i = 1'b1;
  logic hib_req_i = 1'b0, wake_i = 1'b0;
  logic uv_flt_i = 1'b0, uv_en_i = 1'b0, oc_flt_i = 1'b0, oc_en_i = 1'b0;
  logic start_done_i = 1'b0;
  logic rails_en_o, sys_rst_n_o, mem_rst_n_o, reg_rst_o, chip_on_o;
  logic [2:0] state_o;
  logic [3:0] attempt_o;

  int nchk = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .on_pin_i(on_pin_i), .on_pol_i(on_pol_i), .off_short_i(off_short_i),
    .ctl_wr_i(ctl_wr_i), .ctl_chip_on_i(ctl_chip_on_i), .ctl_pcyc_i(ctl_pcyc_i),
    .ctl_hib_rst_i(ctl_hib_rst_i), .hib_req_i(hib_req_i), .wake_i(wake_i),
    .uv_flt_i(uv_flt_i), .uv_en_i(uv_en_i), .oc_flt_i(oc_flt_i), .oc_en_i(oc_en_i),
    .start_done_i(start_done_i), .rails_en_o(rails_en_o), .sys_rst_n_o(sys_rst_n_o),
    .mem_rst_n_o(mem_rst_n_o), .reg_rst_o(reg_rst_o), .chip_on_o(chip_on_o),
    .state_o(state_o), .attempt_o(attempt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic chip, input logic pc, input logic hib);
    ctl_wr_i = 1'b1; ctl_chip_on_i = chip; ctl_pcyc_i = pc; ctl_hib_rst_i = hib;
    step(1);
    ctl_wr_i = 1'b0;
  endtask

  task automatic clear_faults();
    uv_flt_i = 1'b0; uv_en_i = 1'b0; oc_flt_i = 1'b0; oc_en_i = 1'b0; start_done_i = 1'b0;
  endtask

  // Start by software write, then finish start-up cleanly.
  task automatic go_active(input logic pc, input logic hib);
    ctl_write(1'b1, pc, hib);
    start_done_i = 1'b1;
    step(1);
    start_done_i = 1'b0;
  endtask

  // Outcome of a start-up given the flags: 2 ACTIVE, 4 retry wait, 0 OFF.
  function automatic int exp_after_start(bit uv, bit ue, bit oc, bit oe, bit pc);
    bit k = (uv && ue) || (oc && oe);
    if (!k) return 2;
    return pc ? 4 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd715));
    step(3);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 attempts", attempt_o, 0);
    chk("R1 chip_on", chip_on_o, 0);
    chk("R1 rails", rails_en_o, 0);
    chk("R1 sys_rst_n", sys_rst_n_o, 0);
    chk("R1 mem_rst_n", mem_rst_n_o, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 no pulse", reg_rst_o, 0);
    chk("R1 stays off", state_o, 0);

    // R2 software start, R3 success
    ctl_write(1'b1, 1'b0, 1'b1);
    chk("R2 state", state_o, 1);
    chk("R2 chip_on", chip_on_o, 1);
    chk("R2 rails", rails_en_o, 1);
    chk("R2 mem_rst_n", mem_rst_n_o, 1);
    chk("R2 sys_rst_n", sys_rst_n_o, 0);
    start_done_i = 1'b1;
    step(1);
    start_done_i = 1'b0;
    chk("R3 state", state_o, 2);
    chk("R3 sys_rst_n", sys_rst_n_o, 1);

    // R11 hibernate round trip, option at its reset value 1
    hib_req_i = 1'b1; step(1); hib_req_i = 1'b0;
    chk("R11 hib state", state_o, 3);
    chk("R11 hib rails", rails_en_o, 0);
    chk("R11 hib sys_rst_n", sys_rst_n_o, 1);
    wake_i = 1'b1; step(1); wake_i = 1'b0;
    chk("R11 wake state", state_o, 2);
    chk("R11 wake pulse", reg_rst_o, 1);
    step(1);
    chk("R11 pulse one cycle", reg_rst_o, 0);
    ctl_write(1'b1, 1'b0, 1'b0);
    chk("R11 write keeps active", state_o, 2);
    hib_req_i = 1'b1; step(1); hib_req_i = 1'b0;
    wake_i = 1'b1; step(1); wake_i = 1'b0;
    chk("R11 wake no-option state", state_o, 2);
    chk("R11 wake no-option pulse", reg_rst_o, 0);

    // R4 disabled fault ignored in ACTIVE, R13 + R5 + R8 enabled fault shuts down
    uv_flt_i = 1'b1; oc_flt_i = 1'b1;
    step(10);
    chk("R4 disabled fault", state_o, 2);
    uv_en_i = 1'b1;
    step(1);
    chk("R13 R5 fault to off", state_o, 0);
    chk("R8 pulse", reg_rst_o, 1);
    chk("R8 chip_on", chip_on_o, 0);
    chk("R8 rails", rails_en_o, 0);
    chk("R8 sys_rst_n", sys_rst_n_o, 0);
    chk("R8 mem_rst_n", mem_rst_n_o, 0);
    clear_faults();
    step(1);
    chk("R8 pulse ends", reg_rst_o, 0);

    // R2 active-low pin start, R4 window expiry, R5 give up at once
    on_pol_i = 1'b1; on_pin_i = 1'b1;
    step(2);
    chk("R2 polarity change no start", state_o, 0);
    on_pin_i = 1'b0;
    step(1);
    on_pin_i = 1'b1;
    chk("R2 low press starts", state_o, 1);
    chk("R2 pin sets chip_on", chip_on_o, 1);
    step(L);
    chk("R4 window still open", state_o, 1);
    step(1);
    chk("R4 R5 window closes to off", state_o, 0);
    on_pol_i = 1'b0; on_pin_i = 1'b0;
    step(2);

    // R6 R7 full retry budget, no start-up done
    ctl_write(1'b1, 1'b1, 1'b1);
    for (int i = 1; i <= RM; i++) begin
      step(L);
      chk("R6 start window", state_o, 1);
      step(1);
      chk("R6 wait entry", state_o, 4);
      chk("R6 attempt count", attempt_o, i);
      chk("R6 wait rails off", rails_en_o, 0);
      step(RW);
      chk("R6 wait length", state_o, 4);
      step(1);
      chk("R6 wait to start", state_o, 1);
    end
    step(L + 1);
    chk("R7 give up", state_o, 0);
    chk("R7 count cleared", attempt_o, 0);
    chk("R7 chip_on", chip_on_o, 0);

    // R7 fresh budget, R4 enabled fault blocks success, R3 count clears
    ctl_write(1'b1, 1'b1, 1'b1);
    step(L + 1);
    chk("R7 fresh first retry", attempt_o, 1);
    step(RW + 1);
    chk("R6 back to start", state_o, 1);
    uv_flt_i = 1'b1; uv_en_i = 1'b1; start_done_i = 1'b1;
    step(3);
    chk("R4 fault blocks success", state_o, 1);
    uv_flt_i = 1'b0;
    step(1);
    chk("R3 success after clear", state_o, 2);
    chk("R3 count cleared", attempt_o, 0);
    clear_faults();

    // R13 fault in ACTIVE with cycling on, R9 write-off from wait
    oc_flt_i = 1'b1; oc_en_i = 1'b1;
    step(1);
    clear_faults();
    chk("R13 active fault to wait", state_o, 4);
    chk("R13 count", attempt_o, 1);
    ctl_write(1'b0, 1'b0, 1'b1);
    chk("R9 off from wait", state_o, 0);
    chk("R9 count", attempt_o, 0);

    // R12 wake with enabled fault, cycling off
    go_active(1'b0, 1'b1);
    hib_req_i = 1'b1; step(1); hib_req_i = 1'b0;
    uv_flt_i = 1'b1; uv_en_i = 1'b1;
    wake_i = 1'b1; step(1); wake_i = 1'b0;
    chk("R12 wake fault to off", state_o, 0);
    chk("R12 pulse", reg_rst_o, 1);
    clear_faults();

    // Random start-ups
    for (int n = 0; n < 40; n++) begin
      bit uv = 1'($urandom); bit ue = 1'($urandom);
      bit oc = 1'($urandom); bit oe = 1'($urandom);
      bit pc = 1'($urandom);
      int e = exp_after_start(uv, ue, oc, oe, pc);
      ctl_write(1'b1, pc, 1'b1);
      chk("R2 random start", state_o, 1);
      uv_flt_i = uv; uv_en_i = ue; oc_flt_i = oc; oc_en_i = oe; start_done_i = 1'b1;
      step(1);
      if (e == 2) begin
        chk("R3 R4 random success", state_o, 2);
      end else begin
        chk("R4 random blocked", state_o, 1);
        step(L);
        chk("R5 R6 random response", state_o, e);
        chk("R6 random count", attempt_o, (e == 4) ? 1 : 0);
      end
      clear_faults();
      if (e != 0) begin
        ctl_write(1'b0, 1'b0, 1'b1);
        chk("R9 random write off", state_o, 0);
      end
    end

    // R10 hold-to-off, short then long setting
    off_short_i = 1'b1;
    go_active(1'b0, 1'b1);
    on_pin_i = 1'b1;
    step(4990);
    chk("R10 short hold not yet", state_o, 2);
    on_pin_i = 1'b0;
    step(20);
    chk("R10 release keeps active", state_o, 2);
    on_pin_i = 1'b1;
    step(5010);
    chk("R10 short hold off", state_o, 0);
    chk("R10 short chip_on", chip_on_o, 0);
    on_pin_i = 1'b0;
    off_short_i = 1'b0;
    step(2);
    go_active(1'b0, 1'b1);
    on_pin_i = 1'b1;
    step(9990);
    chk("R10 long hold not yet", state_o, 2);
    step(30);
    chk("R10 long hold off", state_o, 0);
    on_pin_i = 1'b0;
    step(2);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule